// File: doc/BRIEF.md
# Prescaled Multichannel Event Scaler

This block counts event pulses on a bank of independent channels. Each channel has a full count of LOW_W + HIGH_W bits, which is 24 bits at the defaults. The low byte of every channel is its own fast counter. The upper part of all channels sits in one shared array of words. A scan pointer walks that array one slot per cycle. When a channel's low byte rolls over, the channel raises a carry-pending flag. The upper word for that channel is then advanced the next time the scan pointer reaches its slot. The array is therefore only touched once per 256 counts, at one slot per cycle.

A load pulse freezes every channel in the same cycle into a snapshot buffer. Any carry that is still pending is folded into the frozen value, so each frozen count is exact. Counting then carries on in the working registers while software reads the snapshot by channel address.

A clear pulse zeroes the working counts. Load and clear each block the count inputs for a short fixed window. A veto level blocks the count inputs for as long as it is high. In test mode the count inputs are blocked, and each test step adds one to every byte of every channel with no carry between bytes. 256 steps therefore drive every bit through a full cycle.

Top module: `scan_scaler`

## Requirements
- R1: Each channel counts one for every cycle in which its `cnt_in` bit is high and counting is open. `rd_data` returns that channel's snapshot with the low byte in bits [7:0] and the upper word above it.
- R2: A low-byte rollover sets a carry that is added to the channel's upper word when the scan pointer reaches that channel. The pointer steps through 0..NCH-1 by one each cycle, except during a test step.
- R3: A `load` freezes all channels in its own cycle, including pending carries. The snapshot stays unchanged until the next load, and counting continues meanwhile. After reset every snapshot word reads 0.
- R4: Count pulses in the `load` cycle and in the HOLD_LOAD cycles after it are ignored. A pulse in the next cycle is counted.
- R5: A `clear` zeroes all working counts and overflow flags, and leaves the snapshot untouched. Pulses in the clear cycle and in the HOLD_CLR cycles after it are ignored.
- R6: While `veto` is high, all count pulses are ignored.
- R7: While `test_mode` is high, count pulses are ignored. Each `test_step` adds one to every byte of every channel, with no carry between bytes, and sets no overflow flag.
- R8: `ovf[i]` goes high when channel i's upper word rolls over from all ones. It stays high until a clear.
- R9: If `load` and `clear` are high in the same cycle, the clear takes effect and no snapshot is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | NCH | One-cycle count pulses, one bit per channel, already synchronous |
| load | input | 1 | Freeze all channels into the snapshot |
| clear | input | 1 | Zero working counts and overflow flags |
| veto | input | 1 | Level that blocks counting |
| test_mode | input | 1 | Test mode; blocks counting and enables test steps |
| test_step | input | 1 | Byte-wise increment of every channel while in test mode |
| rd_addr | input | AW | Snapshot channel select |
| rd_data | output | LOW_W+HIGH_W | Snapshot word of the selected channel |
| ovf | output | NCH | Sticky per-channel overflow flags |

## Verification
The bench builds the block with NCH = 8, HIGH_W = 8, HOLD_LOAD = 3 and HOLD_CLR = 2. A 16-bit count lets a full overflow of one channel happen in 65,536 cycles, which makes R8 and its boundary one count short reachable within the run. The eight-slot scan keeps carries pending for several cycles, so loads that land just after a mass rollover do catch unserved carries. The default byte layout and hold windows are exercised unchanged.

// File: rtl/scan_scaler_pkg.sv
package scan_scaler_pkg;
   // index width that stays at least one bit for tiny banks
   function automatic int idx_bits(int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/scan_scaler_gate.sv
module scan_scaler_gate
   import scan_scaler_pkg::*;
#(
   parameter int HOLD_LOAD = 3,
   parameter int HOLD_CLR  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clear,
   input  logic veto,
   input  logic test_mode,
   output logic cnt_en,
   output logic take,
   output logic wipe
);
   localparam int HMAX = (HOLD_LOAD > HOLD_CLR) ? HOLD_LOAD : HOLD_CLR;
   localparam int HW   = idx_bits(HMAX + 1);

   if (HOLD_LOAD < 1 || HOLD_CLR < 1) begin : g_bad_hold
      $error("scan_scaler_gate: hold windows must be at least one cycle");
   end

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hold_q <= '0;
      else if (clear)           hold_q <= HW'(HOLD_CLR);
      else if (load)            hold_q <= HW'(HOLD_LOAD);
      else if (hold_q != '0)    hold_q <= hold_q - HW'(1);
   end

   assign wipe   = clear;
   assign take   = load & ~clear;
   assign cnt_en = ~(load | clear | veto | test_mode) & (hold_q == '0);
endmodule

// File: rtl/scan_scaler_lowbank.sv
module scan_scaler_lowbank #(
   parameter int NCH   = 32,
   parameter int LOW_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCH-1:0]             cnt_in,
   input  logic                       cnt_en,
   input  logic                       wipe,
   input  logic                       tstep,
   input  logic [NCH-1:0]             served,
   output logic [NCH-1:0][LOW_W-1:0]  lo,
   output logic [NCH-1:0]             pend
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit;
      assign hit = cnt_en & cnt_in[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo[i]   <= '0;
            pend[i] <= 1'b0;
         end else if (wipe) begin
            lo[i]   <= '0;
            pend[i] <= 1'b0;
         end else if (tstep) begin
            lo[i]   <= lo[i] + LOW_W'(1);
         end else begin
            if (hit) lo[i] <= lo[i] + LOW_W'(1);
            pend[i] <= (pend[i] & ~served[i]) | (hit & (lo[i] == '1));
         end
      end
   end
endmodule

// File: rtl/scan_scaler_highmem.sv
module scan_scaler_highmem
   import scan_scaler_pkg::*;
#(
   parameter int NCH    = 32,
   parameter int HIGH_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wipe,
   input  logic                        tstep,
   input  logic [NCH-1:0]              pend,
   output logic [NCH-1:0]              served,
   output logic [NCH-1:0][HIGH_W-1:0]  hi,
   output logic [idx_bits(NCH)-1:0]    ptr,
   output logic [NCH-1:0]              ovf
);
   localparam int AW = idx_bits(NCH);
   localparam int NB = HIGH_W / 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ptr <= '0;
      else if (!tstep) begin
         if (ptr == AW'(NCH - 1))   ptr <= '0;
         else                       ptr <= ptr + AW'(1);
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_slot
      logic [HIGH_W-1:0] bump;
      logic              apply;

      assign served[i] = ~tstep & (ptr == AW'(i));
      assign apply     = served[i] & pend[i];

      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign bump[b*8 +: 8] = hi[i][b*8 +: 8] + 8'd1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi[i]  <= '0;
            ovf[i] <= 1'b0;
         end else if (wipe) begin
            hi[i]  <= '0;
            ovf[i] <= 1'b0;
         end else if (tstep) begin
            hi[i]  <= bump;
         end else if (apply) begin
            hi[i]  <= hi[i] + HIGH_W'(1);
            if (hi[i] == '1) ovf[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/scan_scaler_snap.sv
module scan_scaler_snap
   import scan_scaler_pkg::*;
#(
   parameter int NCH    = 32,
   parameter int LOW_W  = 8,
   parameter int HIGH_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        take,
   input  logic [NCH-1:0][LOW_W-1:0]   lo,
   input  logic [NCH-1:0][HIGH_W-1:0]  hi,
   input  logic [NCH-1:0]              pend,
   input  logic [idx_bits(NCH)-1:0]    rd_addr,
   output logic [LOW_W+HIGH_W-1:0]     rd_data
);
   localparam int CW = LOW_W + HIGH_W;

   logic [NCH-1:0][CW-1:0] snap;

   for (genvar i = 0; i < NCH; i++) begin : g_frz
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     snap[i] <= '0;
         else if (take)  snap[i] <= {hi[i] + HIGH_W'(pend[i]), lo[i]};
      end
   end

   assign rd_data = (int'(rd_addr) < NCH) ? snap[rd_addr] : '0;
endmodule

// File: rtl/scan_scaler.sv
module scan_scaler
   import scan_scaler_pkg::*;
#(
   parameter int NCH       = 32,
   parameter int LOW_W     = 8,
   parameter int HIGH_W    = 16,
   parameter int HOLD_LOAD = 3,
   parameter int HOLD_CLR  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NCH-1:0]              cnt_in,
   input  logic                        load,
   input  logic                        clear,
   input  logic                        veto,
   input  logic                        test_mode,
   input  logic                        test_step,
   input  logic [idx_bits(NCH)-1:0]    rd_addr,
   output logic [LOW_W+HIGH_W-1:0]     rd_data,
   output logic [NCH-1:0]              ovf
);
   localparam int AW = idx_bits(NCH);
   localparam int CW = LOW_W + HIGH_W;

   if (LOW_W != 8 || HIGH_W < 8 || (HIGH_W % 8) != 0) begin : g_bad_width
      $error("scan_scaler: low part must be one byte, upper part whole bytes");
   end
   if (NCH < 1 || NCH > (1 << LOW_W)) begin : g_bad_nch
      $error("scan_scaler: scan must finish within one low-byte turn");
   end

   logic                       cnt_en, take, wipe, tstep;
   logic [NCH-1:0]             pend, served;
   logic [NCH-1:0][LOW_W-1:0]  lo;
   logic [NCH-1:0][HIGH_W-1:0] hi;
   logic [AW-1:0]              scan_ptr;

   assign tstep = test_mode & test_step & ~load & ~clear;

   scan_scaler_gate #(.HOLD_LOAD(HOLD_LOAD), .HOLD_CLR(HOLD_CLR)) u_gate (
      .clk(clk), .rst_n(rst_n), .load(load), .clear(clear), .veto(veto),
      .test_mode(test_mode), .cnt_en(cnt_en), .take(take), .wipe(wipe));

   scan_scaler_lowbank #(.NCH(NCH), .LOW_W(LOW_W)) u_low (
      .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .cnt_en(cnt_en),
      .wipe(wipe), .tstep(tstep), .served(served), .lo(lo), .pend(pend));

   scan_scaler_highmem #(.NCH(NCH), .HIGH_W(HIGH_W)) u_high (
      .clk(clk), .rst_n(rst_n), .wipe(wipe), .tstep(tstep), .pend(pend),
      .served(served), .hi(hi), .ptr(scan_ptr), .ovf(ovf));

   scan_scaler_snap #(.NCH(NCH), .LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .take(take), .lo(lo), .hi(hi), .pend(pend),
      .rd_addr(rd_addr), .rd_data(rd_data));
endmodule

// File: rtl/scan_scaler_chk.sv
module scan_scaler_chk #(
   parameter int NCH = 32,
   parameter int AW  = 5,
   parameter int CW  = 24
) (
   input logic           clk,
   input logic           rst_n,
   input logic           load,
   input logic           clear,
   input logic           veto,
   input logic           test_mode,
   input logic           test_step,
   input logic           cnt_en,
   input logic [AW-1:0]  scan_ptr,
   input logic [NCH-1:0] ovf,
   input logic [AW-1:0]  rd_addr,
   input logic [CW-1:0]  rd_data
);
   p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_mode && test_step && !load && !clear) |=>
         scan_ptr == (($past(scan_ptr) == AW'(NCH - 1)) ? '0 : $past(scan_ptr) + AW'(1)));

   p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(rd_addr) -> $stable(rd_data)));

   p_load_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !cnt_en);

   p_clear_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> ovf == '0);

   p_veto_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      veto |-> !cnt_en);

   p_test_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> !cnt_en);

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (ovf & $past(ovf)) == $past(ovf));
endmodule

bind scan_scaler scan_scaler_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .load(load), .clear(clear), .veto(veto),
   .test_mode(test_mode), .test_step(test_step), .cnt_en(cnt_en),
   .scan_ptr(scan_ptr), .ovf(ovf), .rd_addr(rd_addr), .rd_data(rd_data));

// File: tb/scan_scaler_tb.sv
`timescale 1ns/100ps
module scan_scaler_tb;
   localparam int NCH = 8, LW = 8, HW = 8, HL = 3, HC = 2;
   localparam int CW  = LW + HW;
   localparam int AW  = 3;
   localparam int MSK = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NCH-1:0] cnt_in = '0;
   logic load = 0, clear = 0, veto = 0, test_mode = 0, test_step = 0;
   logic [AW-1:0] rd_addr = '0;
   logic [CW-1:0] rd_data;
   logic [NCH-1:0] ovf;

   int checks = 0, errors = 0;
   bit done = 0;
   int unsigned exp_c[NCH];
   int unsigned snap_e[NCH];

   always #2 clk = ~clk;

   scan_scaler #(.NCH(NCH), .LOW_W(LW), .HIGH_W(HW), .HOLD_LOAD(HL), .HOLD_CLR(HC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .load(load), .clear(clear),
      .veto(veto), .test_mode(test_mode), .test_step(test_step),
      .rd_addr(rd_addr), .rd_data(rd_data), .ovf(ovf));

   task automatic chk(string req, int unsigned act, int unsigned expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic drive(logic [NCH-1:0] m, int n);
      for (int c = 0; c < n; c++) begin
         @(negedge clk) cnt_in = m;
         for (int i = 0; i < NCH; i++) if (m[i]) exp_c[i] = (exp_c[i] + 1) & MSK;
      end
      @(negedge clk) cnt_in = '0;
   endtask

   task automatic raw(logic [NCH-1:0] m, int n);
      for (int c = 0; c < n; c++) @(negedge clk) cnt_in = m;
      @(negedge clk) cnt_in = '0;
   endtask

   task automatic do_load();
      @(negedge clk) load = 1;
      @(negedge clk) load = 0;
      for (int i = 0; i < NCH; i++) snap_e[i] = exp_c[i];
      repeat (HL) @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk) clear = 1;
      @(negedge clk) clear = 0;
      for (int i = 0; i < NCH; i++) exp_c[i] = 0;
      repeat (HC) @(negedge clk);
   endtask

   task automatic check_snap(string req);
      for (int i = 0; i < NCH; i++) begin
         @(negedge clk) rd_addr = AW'(i);
         #1 chk(req, rd_data, snap_e[i]);
      end
   endtask

   task automatic t_reset();
      #1 chk("R8 reset ovf", ovf, 0);
      check_snap("R3 reset snapshot");
   endtask

   task automatic t_mixed();   // R1 R2
      logic [NCH-1:0] m;
      do_clear();
      for (int c = 0; c < 7 * 301 + 9; c++) begin
         for (int i = 0; i < NCH; i++) m[i] = (c < i * 301 + 9);
         drive(m, 1);
      end
      repeat (2 * NCH) @(negedge clk);
      do_load();
      check_snap("R1 R2 mixed counts");
   endtask

   task automatic t_fold();    // R3
      do_clear();
      drive('1, 256);
      do_load();
      check_snap("R3 pending carry folded");
      drive('1, 5);
      check_snap("R3 snapshot stable while counting");
      do_load();
      check_snap("R3 next load");
   endtask

   task automatic t_hold();    // R4
      @(negedge clk) begin load = 1; cnt_in = '1; end
      @(negedge clk) load = 0;
      for (int i = 0; i < NCH; i++) snap_e[i] = exp_c[i];
      repeat (HL) @(negedge clk);
      cnt_in = 8'h01;
      exp_c[0] = (exp_c[0] + 1) & MSK;
      @(negedge clk) cnt_in = '0;
      do_load();
      check_snap("R4 load window ignored, next cycle counted");
   endtask

   task automatic t_clear();   // R5
      @(negedge clk) begin clear = 1; cnt_in = '1; end
      @(negedge clk) clear = 0;
      for (int i = 0; i < NCH; i++) exp_c[i] = 0;
      repeat (HC) @(negedge clk);
      cnt_in = 8'h02;
      exp_c[1] = 1;
      @(negedge clk) cnt_in = '0;
      check_snap("R5 snapshot kept over clear");
      do_load();
      check_snap("R5 clear window ignored");
   endtask

   task automatic t_veto();    // R6
      @(negedge clk) veto = 1;
      raw('1, 10);
      @(negedge clk) veto = 0;
      drive(8'h80, 3);
      do_load();
      check_snap("R6 veto blocks");
   endtask

   task automatic t_test();    // R7
      do_clear();
      drive(8'h02, 511);
      repeat (2 * NCH) @(negedge clk);
      @(negedge clk) test_mode = 1;
      raw('1, 5);
      for (int s = 0; s < 3; s++) begin
         @(negedge clk) test_step = 1;
         @(negedge clk) test_step = 0;
      end
      @(negedge clk) test_mode = 0;
      for (int i = 0; i < NCH; i++)
         exp_c[i] = (((exp_c[i] >> 8) + 3) & 8'hFF) << 8 | ((exp_c[i] + 3) & 8'hFF);
      do_load();
      check_snap("R7 byte-wise test step");
      chk("R7 test sets no ovf", ovf, 0);
   endtask

   task automatic t_ovf();     // R8
      do_clear();
      drive(8'h01, 65535);
      repeat (2 * NCH) @(negedge clk);
      #1 chk("R8 no ovf one short", ovf, 0);
      drive(8'h01, 1);
      repeat (2 * NCH) @(negedge clk);
      #1 chk("R8 ovf set on wrap", ovf, 1);
      do_load();
      check_snap("R8 count wrapped to zero");
      drive(8'h01, 1);
      repeat (2 * NCH) @(negedge clk);
      #1 chk("R8 ovf sticky", ovf, 1);
      do_clear();
      #1 chk("R8 ovf cleared", ovf, 0);
   endtask

   task automatic t_prio();    // R9
      drive(8'h0F, 4);
      @(negedge clk) begin load = 1; clear = 1; end
      @(negedge clk) begin load = 0; clear = 0; end
      for (int i = 0; i < NCH; i++) exp_c[i] = 0;
      repeat (HC + 1) @(negedge clk);
      check_snap("R9 clear wins, no snapshot");
      do_load();
      check_snap("R9 counts cleared");
   endtask

   initial begin
      for (int i = 0; i < NCH; i++) begin exp_c[i] = 0; snap_e[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_mixed();
      t_fold();
      t_hold();
      t_clear();
      t_veto();
      t_test();
      t_ovf();
      t_prio();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule